// File: doc/BRIEF.md
# Pipelined Multiply-Add Arithmetic Slice

This block is a 48-bit arithmetic slice. The final stage is either an adder/subtracter or a bitwise logic unit. Three operand selectors (X, Y and Z) feed that stage. Its inputs can come from a 25x18 signed multiplier, from a 25-bit pre-adder that sits in front of the multiplier, from the data ports or from the registered result. The result register P is fed back as a selectable operand. This lets the slice accumulate, or combine a new product with the previous result.

Every data and control path has its own optional pipeline registers. A parameter sets the depth of each: A and B take 0 to 2 stages, and the others take 0 or 1. Each stage has its own clock-enable and its own synchronous reset. The global reset is asynchronous. The multiplier hands the final adder two sign-extended partial products. Their sum is the full product.

Top module: `arith_slice`

## Requirements
- R1: With x_sel 01, y_sel 01, z_sel 10 and alu_mode 0000, P becomes C + A*B. A (25 bits) and B (18 bits) are two's complement, and the sum wraps modulo 2^48.
- R2: alu_mode 0001 gives P = Z - (X + Y + CIN).
- R3: alu_mode 0010 gives P = -Z + (X + Y + CIN) - 1. alu_mode 0011 gives P = -Z - X - Y - CIN - 1.
- R4: When pre_add_i is 1, the multiplier uses D + A (wrapping at 25 bits) in place of A.
- R5: The selectors use these codes. X: 00 zero, 01 multiplier, 10 P, 11 the concatenation {A,B}, zero-extended to 48 bits. Y: 00 zero, 01 multiplier, 10 all ones, 11 C. Z: 00 zero, 01 P, 10 C, 11 zero.
- R6: If only one of X and Y selects the multiplier, the result is zero.
- R7: alu_mode codes 0100 to 1111 select a bitwise operation on X and Z. The codes are: 0100 AND, 0101 OR, 0110 XOR, 0111 XNOR, 1000 NAND, 1001 NOR, 1010 NOT X, 1011 NOT Z, 1100 X AND NOT Z, 1101 X OR NOT Z, 1110 X, 1111 Z. In these modes y_sel has no effect, and an X multiplier select reads as zero.
- R8: With the default register depths, a result is valid once its inputs have been held for 5 clock edges. With every stage bypassed, P shows the result one edge after the inputs change.
- R9: P loads only when ce_p_i is 1. rst_p_i clears P to zero on the next edge and takes priority over ce_p_i.
- R10: Each stage's synchronous reset clears that stage's register. For example, rst_a_i makes A read as zero. The reset has no effect when that stage is bypassed.
- R11: rst_ni low clears P to zero at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 25 | Multiplier operand A, signed |
| b_i | input | 18 | Multiplier operand B, signed |
| c_i | input | 48 | Addend C |
| d_i | input | 25 | Pre-adder operand D |
| cin_i | input | 1 | Carry-in |
| pre_add_i | input | 1 | Use D + A as the multiplier operand |
| x_sel_i | input | 2 | X selector code |
| y_sel_i | input | 2 | Y selector code |
| z_sel_i | input | 2 | Z selector code |
| alu_mode_i | input | 4 | Final-stage operation code |
| ce_a_i | input | 1 | Enable for the A stages |
| ce_b_i | input | 1 | Enable for the B stages |
| ce_c_i | input | 1 | Enable for the C stage |
| ce_d_i | input | 1 | Enable for the D stage |
| ce_ad_i | input | 1 | Enable for the pre-adder stage |
| ce_m_i | input | 1 | Enable for the multiplier stage |
| ce_ctrl_i | input | 1 | Enable for the control stage |
| ce_p_i | input | 1 | Enable for the P register |
| rst_a_i | input | 1 | Synchronous clear of the A stages |
| rst_b_i | input | 1 | Synchronous clear of the B stages |
| rst_c_i | input | 1 | Synchronous clear of the C stage |
| rst_d_i | input | 1 | Synchronous clear of the D stage |
| rst_ad_i | input | 1 | Synchronous clear of the pre-adder stage |
| rst_m_i | input | 1 | Synchronous clear of the multiplier stage |
| rst_ctrl_i | input | 1 | Synchronous clear of the control stage |
| rst_p_i | input | 1 | Synchronous clear of P |
| p_o | output | 48 | Registered result |

## Verification
All internal state sits in the pipeline stages and in P. A stage that holds a stale or corrupt value therefore shows up as a wrong P value once the inputs have been held for the pipeline depth. The bypassed instance shows it one edge later.

A fault in the feedback path or in the P enable shows differently. It appears only when P is selected as an operand, so the bench freezes P, changes the operands, and then releases P for exactly one edge to expose it.

Selector and mode faults show as a wrong sum or wrong bits on the first result that uses the affected code.

// File: rtl/slice_pkg.sv
package slice_pkg;
  typedef enum logic [1:0] {XS_ZERO = 2'd0, XS_MULT = 2'd1, XS_P = 2'd2, XS_AB = 2'd3} x_sel_e;
  typedef enum logic [1:0] {YS_ZERO = 2'd0, YS_MULT = 2'd1, YS_ONES = 2'd2, YS_C = 2'd3} y_sel_e;
  typedef enum logic [1:0] {ZS_ZERO = 2'd0, ZS_P = 2'd1, ZS_C = 2'd2, ZS_RSVD = 2'd3} z_sel_e;

  // single table of final-stage codes; bits [3:2] != 0 means logic mode
  typedef enum logic [3:0] {
    ALU_ADD     = 4'b0000,
    ALU_SUB     = 4'b0001,
    ALU_NEG_ADD = 4'b0010,
    ALU_NEG_SUB = 4'b0011,
    LOG_AND     = 4'b0100,
    LOG_OR      = 4'b0101,
    LOG_XOR     = 4'b0110,
    LOG_XNOR    = 4'b0111,
    LOG_NAND    = 4'b1000,
    LOG_NOR     = 4'b1001,
    LOG_NOTX    = 4'b1010,
    LOG_NOTZ    = 4'b1011,
    LOG_ANDN    = 4'b1100,
    LOG_ORN     = 4'b1101,
    LOG_PASSX   = 4'b1110,
    LOG_PASSZ   = 4'b1111
  } alu_mode_e;

  typedef struct packed {
    logic      pre_add;
    x_sel_e    xs;
    y_sel_e    ys;
    z_sel_e    zs;
    alu_mode_e mode;
    logic      cin;
  } ctrl_t;
endpackage

// File: rtl/slice_pipe.sv
module slice_pipe #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ce_i,
  input  logic         srst_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_bypass
    logic unused_ctl;
    assign unused_ctl = ^{clk_i, rst_ni, ce_i, srst_i};
    assign q_o = d_i;
  end else begin : g_stages
    logic [W-1:0] st_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
      end else if (srst_i) begin
        for (int i = 0; i < DEPTH; i++) st_q[i] <= '0;
      end else if (ce_i) begin
        st_q[0] <= d_i;
        for (int i = 1; i < DEPTH; i++) st_q[i] <= st_q[i-1];
      end
    end
    assign q_o = st_q[DEPTH-1];

    // R10: a synchronous clear empties the last stage on the next edge
    assert_stage_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      srst_i |=> q_o == '0);
  end
endmodule

// File: rtl/slice_mult.sv
module slice_mult #(
  parameter int A_W   = 25,
  parameter int B_W   = 18,
  parameter int P_W   = 48,
  parameter int ADREG = 1,
  parameter int MREG  = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] a_i,
  input  logic [A_W-1:0] d_i,
  input  logic [B_W-1:0] b_i,
  input  logic           pre_add_i,
  input  logic           ce_ad_i,
  input  logic           rst_ad_i,
  input  logic           ce_m_i,
  input  logic           rst_m_i,
  output logic [P_W-1:0] pp_hi_o,
  output logic [P_W-1:0] pp_lo_o
);
  localparam int LO_W = B_W / 2;

  logic [A_W-1:0] ad_d, ad_q;
  logic signed [P_W-1:0] a_ext, hi_ext, lo_ext, pp_hi, pp_lo;
  logic [2*P_W-1:0] m_q;

  assign ad_d = pre_add_i ? (a_i + d_i) : a_i;

  slice_pipe #(.W(A_W), .DEPTH(ADREG)) u_ad (
    .clk_i, .rst_ni, .ce_i(ce_ad_i), .srst_i(rst_ad_i), .d_i(ad_d), .q_o(ad_q));

  // split B: signed upper half, unsigned lower half
  assign a_ext  = P_W'($signed(ad_q));
  assign hi_ext = P_W'($signed(b_i[B_W-1:LO_W]));
  assign lo_ext = P_W'($signed({1'b0, b_i[LO_W-1:0]}));
  assign pp_lo  = a_ext * lo_ext;
  assign pp_hi  = (a_ext * hi_ext) <<< LO_W;

  slice_pipe #(.W(2*P_W), .DEPTH(MREG)) u_m (
    .clk_i, .rst_ni, .ce_i(ce_m_i), .srst_i(rst_m_i),
    .d_i({pp_hi, pp_lo}), .q_o(m_q));

  assign pp_hi_o = m_q[2*P_W-1:P_W];
  assign pp_lo_o = m_q[P_W-1:0];

  // R1: partial products together equal the full signed product
  assert_split_sum_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pp_hi + pp_lo) == (a_ext * P_W'($signed(b_i))));
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_pkg::*;
#(
  parameter int P_W = 48
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  ctrl_t          ctrl_i,
  input  logic [P_W-1:0] pp_hi_i,
  input  logic [P_W-1:0] pp_lo_i,
  input  logic [P_W-1:0] ab_i,
  input  logic [P_W-1:0] c_i,
  input  logic [P_W-1:0] p_i,
  output logic [P_W-1:0] res_o,
  output logic           illegal_o
);
  logic           logic_mode;
  logic [P_W-1:0] x_op, y_op, z_op, sum_s, arith_r, logic_r;

  assign logic_mode = ctrl_i.mode[3] | ctrl_i.mode[2];
  assign illegal_o  = (ctrl_i.xs == XS_MULT) != (ctrl_i.ys == YS_MULT);

  always_comb begin
    case (ctrl_i.xs)
      XS_MULT: x_op = logic_mode ? '0 : pp_hi_i;
      XS_P:    x_op = p_i;
      XS_AB:   x_op = ab_i;
      default: x_op = '0;
    endcase
    if (logic_mode) y_op = '0;
    else begin
      case (ctrl_i.ys)
        YS_MULT: y_op = pp_lo_i;
        YS_ONES: y_op = '1;
        YS_C:    y_op = c_i;
        default: y_op = '0;
      endcase
    end
    case (ctrl_i.zs)
      ZS_P:    z_op = p_i;
      ZS_C:    z_op = c_i;
      default: z_op = '0;
    endcase
  end

  assign sum_s = x_op + y_op + P_W'(ctrl_i.cin);

  // negated forms reuse one adder through inversion identities
  always_comb begin
    case (ctrl_i.mode)
      ALU_ADD:     arith_r = z_op + sum_s;
      ALU_SUB:     arith_r = ~(~z_op + sum_s);
      ALU_NEG_ADD: arith_r = ~z_op + sum_s;
      default:     arith_r = ~(z_op + sum_s);
    endcase
    case (ctrl_i.mode)
      LOG_AND:   logic_r = x_op & z_op;
      LOG_OR:    logic_r = x_op | z_op;
      LOG_XOR:   logic_r = x_op ^ z_op;
      LOG_XNOR:  logic_r = ~(x_op ^ z_op);
      LOG_NAND:  logic_r = ~(x_op & z_op);
      LOG_NOR:   logic_r = ~(x_op | z_op);
      LOG_NOTX:  logic_r = ~x_op;
      LOG_NOTZ:  logic_r = ~z_op;
      LOG_ANDN:  logic_r = x_op & ~z_op;
      LOG_ORN:   logic_r = x_op | ~z_op;
      LOG_PASSX: logic_r = x_op;
      default:   logic_r = z_op;
    endcase
  end

  assign res_o = illegal_o ? '0 : (logic_mode ? logic_r : arith_r);

  // R2: subtract form restores Z when the operand sum is added back
  assert_sub_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mode == ALU_SUB && !illegal_o) |-> (res_o + sum_s) == z_op);
  // R3: negated-add form satisfies res + Z + 1 == X + Y + CIN
  assert_negadd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mode == ALU_NEG_ADD && !illegal_o) |-> (res_o + z_op + P_W'(1)) == sum_s);
endmodule

// File: rtl/arith_slice.sv
module arith_slice
  import slice_pkg::*;
#(
  parameter int A_W     = 25,
  parameter int B_W     = 18,
  parameter int P_W     = 48,
  parameter int AREG    = 2,
  parameter int BREG    = 2,
  parameter int CREG    = 1,
  parameter int DREG    = 1,
  parameter int ADREG   = 1,
  parameter int MREG    = 1,
  parameter int CTRLREG = 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic [P_W-1:0] c_i,
  input  logic [A_W-1:0] d_i,
  input  logic           cin_i,
  input  logic           pre_add_i,
  input  logic [1:0]     x_sel_i,
  input  logic [1:0]     y_sel_i,
  input  logic [1:0]     z_sel_i,
  input  logic [3:0]     alu_mode_i,
  input  logic           ce_a_i,
  input  logic           ce_b_i,
  input  logic           ce_c_i,
  input  logic           ce_d_i,
  input  logic           ce_ad_i,
  input  logic           ce_m_i,
  input  logic           ce_ctrl_i,
  input  logic           ce_p_i,
  input  logic           rst_a_i,
  input  logic           rst_b_i,
  input  logic           rst_c_i,
  input  logic           rst_d_i,
  input  logic           rst_ad_i,
  input  logic           rst_m_i,
  input  logic           rst_ctrl_i,
  input  logic           rst_p_i,
  output logic [P_W-1:0] p_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [A_W-1:0] a_q, d_q;
  logic [B_W-1:0] b_q;
  logic [P_W-1:0] c_q, pp_hi, pp_lo, ab_ext, alu_res, p_q;
  ctrl_t          ctrl_d, ctrl_q;
  logic           alu_illegal;

  assign ctrl_d = {pre_add_i, x_sel_i, y_sel_i, z_sel_i, alu_mode_i, cin_i};

  slice_pipe #(.W(A_W), .DEPTH(AREG)) u_a (
    .clk_i, .rst_ni, .ce_i(ce_a_i), .srst_i(rst_a_i), .d_i(a_i), .q_o(a_q));
  slice_pipe #(.W(B_W), .DEPTH(BREG)) u_b (
    .clk_i, .rst_ni, .ce_i(ce_b_i), .srst_i(rst_b_i), .d_i(b_i), .q_o(b_q));
  slice_pipe #(.W(P_W), .DEPTH(CREG)) u_c (
    .clk_i, .rst_ni, .ce_i(ce_c_i), .srst_i(rst_c_i), .d_i(c_i), .q_o(c_q));
  slice_pipe #(.W(A_W), .DEPTH(DREG)) u_d (
    .clk_i, .rst_ni, .ce_i(ce_d_i), .srst_i(rst_d_i), .d_i(d_i), .q_o(d_q));
  slice_pipe #(.W(CTRL_W), .DEPTH(CTRLREG)) u_ctrl (
    .clk_i, .rst_ni, .ce_i(ce_ctrl_i), .srst_i(rst_ctrl_i), .d_i(ctrl_d), .q_o(ctrl_q));

  slice_mult #(.A_W(A_W), .B_W(B_W), .P_W(P_W), .ADREG(ADREG), .MREG(MREG)) u_mult (
    .clk_i, .rst_ni, .a_i(a_q), .d_i(d_q), .b_i(b_q), .pre_add_i(ctrl_q.pre_add),
    .ce_ad_i, .rst_ad_i, .ce_m_i, .rst_m_i, .pp_hi_o(pp_hi), .pp_lo_o(pp_lo));

  assign ab_ext = P_W'({a_q, b_q});

  slice_alu #(.P_W(P_W)) u_alu (
    .clk_i, .rst_ni, .ctrl_i(ctrl_q), .pp_hi_i(pp_hi), .pp_lo_i(pp_lo),
    .ab_i(ab_ext), .c_i(c_q), .p_i(p_q), .res_o(alu_res), .illegal_o(alu_illegal));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      p_q <= '0;
    else if (rst_p_i) p_q <= '0;
    else if (ce_p_i)  p_q <= alu_res;
  end

  assign p_o = p_q;

  assert_p_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_p_i |=> p_o == '0);
  assert_p_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rst_p_i && !ce_p_i) |=> $stable(p_o));
  assert_illegal_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_illegal && ce_p_i && !rst_p_i) |=> p_o == '0);
endmodule

// File: tb/arith_slice_test.sv
`timescale 1ns/1ps
module arith_slice_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [24:0] a_i = '0, d_i = '0;
  logic [17:0] b_i = '0;
  logic [47:0] c_i = '0;
  logic        cin_i = 1'b0, pre_add_i = 1'b0;
  logic [1:0]  x_sel_i = '0, y_sel_i = '0, z_sel_i = '0;
  logic [3:0]  alu_mode_i = '0;
  logic ce_a_i = 1, ce_b_i = 1, ce_c_i = 1, ce_d_i = 1, ce_ad_i = 1, ce_m_i = 1, ce_ctrl_i = 1, ce_p_i = 1;
  logic rst_a_i = 0, rst_b_i = 0, rst_c_i = 0, rst_d_i = 0, rst_ad_i = 0, rst_m_i = 0, rst_ctrl_i = 0, rst_p_i = 0;
  logic [47:0] p_full, p_byp;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [47:0] p_model = '0;
  logic [47:0] exp_f_q[$], exp_b_q[$];
  string tag_q[$];
  event ev;

  always #2.5 clk_i = ~clk_i;

  arith_slice uut (.p_o(p_full), .*);
  arith_slice #(.AREG(0), .BREG(0), .CREG(0), .DREG(0), .ADREG(0), .MREG(0), .CTRLREG(0))
    uut_byp (.p_o(p_byp), .*);

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] model(input logic [24:0] a, input logic [17:0] b,
      input logic [47:0] c, input logic [24:0] d, input logic cin, input logic pre,
      input logic [1:0] xs, input logic [1:0] ys, input logic [1:0] zs,
      input logic [3:0] md, input logic [47:0] p);
    logic [24:0] am;
    logic [47:0] prod, xv, yv, zv, s;
    logic lm;
    am = pre ? a + d : a;
    prod = {{23{am[24]}}, am} * {{30{b[17]}}, b};
    lm = md[3] | md[2];
    case (xs) 2'd1: xv = lm ? 48'd0 : prod; 2'd2: xv = p; 2'd3: xv = {5'd0, a, b}; default: xv = '0; endcase
    if (lm) yv = '0;
    else case (ys) 2'd2: yv = '1; 2'd3: yv = c; default: yv = '0; endcase
    case (zs) 2'd1: zv = p; 2'd2: zv = c; default: zv = '0; endcase
    s = xv + yv + {47'd0, cin};
    if ((xs == 2'd1) != (ys == 2'd1)) return '0;
    case (md)
      4'd0: return zv + s;
      4'd1: return zv - s;
      4'd2: return s - zv - 48'd1;
      4'd3: return 48'd0 - zv - s - 48'd1;
      4'd4: return xv & zv;
      4'd5: return xv | zv;
      4'd6: return xv ^ zv;
      4'd7: return ~(xv ^ zv);
      4'd8: return ~(xv & zv);
      4'd9: return ~(xv | zv);
      4'd10: return ~xv;
      4'd11: return ~zv;
      4'd12: return xv & ~zv;
      4'd13: return xv | ~zv;
      4'd14: return xv;
      default: return zv;
    endcase
  endfunction

  task automatic drive(input logic [24:0] a, input logic [17:0] b, input logic [47:0] c,
      input logic [24:0] d, input logic cin, input logic pre, input logic [1:0] xs,
      input logic [1:0] ys, input logic [1:0] zs, input logic [3:0] md);
    @(negedge clk_i);
    a_i = a; b_i = b; c_i = c; d_i = d; cin_i = cin; pre_add_i = pre;
    x_sel_i = xs; y_sel_i = ys; z_sel_i = zs; alu_mode_i = md;
  endtask

  task automatic push(input logic [47:0] ef, input logic [47:0] eb, input string tag);
    exp_f_q.push_back(ef); exp_b_q.push_back(eb); tag_q.push_back(tag);
    -> ev;
  endtask

  // held operation: bypass copy checked after one edge, both pushed after six
  task automatic run(input logic [24:0] a, input logic [17:0] b, input logic [47:0] c,
      input logic [24:0] d, input logic cin, input logic pre, input logic [1:0] xs,
      input logic [1:0] ys, input logic [1:0] zs, input logic [3:0] md, input string tag);
    logic [47:0] e;
    drive(a, b, c, d, cin, pre, xs, ys, zs, md);
    e = model(a, b, c, d, cin, pre, xs, ys, zs, md, p_model);
    @(negedge clk_i);
    check({tag, " R8 bypass one edge"}, p_byp, e);
    repeat (5) @(negedge clk_i);
    push(e, e, tag);
    p_model = e;
  endtask

  initial begin : monitor
    forever begin
      @(ev);
      while (exp_f_q.size() > 0) begin
        logic [47:0] ef, eb;
        string t;
        ef = exp_f_q.pop_front(); eb = exp_b_q.pop_front(); t = tag_q.pop_front();
        check({t, " piped"}, p_full, ef);
        check({t, " bypassed"}, p_byp, eb);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    logic [47:0] held;
    repeat (3) @(negedge clk_i);
    check("R11 reset piped", p_full, '0);
    check("R11 reset bypassed", p_byp, '0);
    rst_ni = 1'b1;

    // R1 multiply-add at signed corners
    run(25'h0FFFFFF, 18'h20000, 48'h0, 25'h0, 0, 0, 2'd1, 2'd1, 2'd2, 4'd0, "R1 maxpos*minneg");
    run(25'h1000000, 18'h20000, 48'hFFFF_FFFF_FFFF, 25'h0, 0, 0, 2'd1, 2'd1, 2'd2, 4'd0, "R1 minneg*minneg");
    run(25'h1FFFFFF, 18'h1FFFF, 48'h0000_1234_5678, 25'h0, 1, 0, 2'd1, 2'd1, 2'd2, 4'd0, "R1 -1*maxpos cin");
    // R2 subtract
    run(25'd12345, 18'h3FD5A, 48'h0000_0100_0000, 25'h0, 1, 0, 2'd1, 2'd1, 2'd2, 4'd1, "R2 C-A*B-cin");
    run(25'h1000000, 18'h1FFFF, 48'h0, 25'h0, 0, 0, 2'd1, 2'd1, 2'd2, 4'd1, "R2 0-minneg*maxpos");
    // R3 negated forms
    run(25'd300, 18'd7, 48'd5000, 25'h0, 0, 0, 2'd1, 2'd1, 2'd2, 4'd2, "R3 -Z+S-1");
    run(25'd300, 18'd7, 48'd5000, 25'h0, 1, 0, 2'd1, 2'd1, 2'd2, 4'd3, "R3 -Z-S-1");
    // R4 pre-adder, including 25-bit wrap
    run(25'h0FFFFFF, 18'd2, 48'h0, 25'h1, 0, 1, 2'd1, 2'd1, 2'd2, 4'd0, "R4 D+A wraps");
    run(25'd100, 18'h3FFFD, 48'd10, 25'h1FFFFCE, 0, 1, 2'd1, 2'd1, 2'd2, 4'd0, "R4 D+A signed");
    // R5 selectors
    run(25'h1ABCDEF, 18'h2F0F0, 48'h1111_2222_3333, 25'h0, 0, 0, 2'd3, 2'd3, 2'd0, 4'd0, "R5 AB+C");
    run(25'h0000123, 18'h00456, 48'h0000_0000_9999, 25'h0, 1, 0, 2'd3, 2'd2, 2'd2, 4'd0, "R5 AB+ones+C");
    run(25'h0, 18'h0, 48'hABCD, 25'h0, 1, 0, 2'd0, 2'd0, 2'd3, 4'd0, "R5 Z reserved");
    // R6 one-sided multiplier select
    run(25'd9, 18'd9, 48'h77, 25'h0, 0, 0, 2'd1, 2'd0, 2'd2, 4'd0, "R6 X only");
    run(25'd3, 18'd3, 48'h55, 25'h0, 0, 0, 2'd3, 2'd0, 2'd2, 4'd0, "R5 restore");
    run(25'd9, 18'd9, 48'h77, 25'h0, 0, 0, 2'd0, 2'd1, 2'd2, 4'd0, "R6 Y only");
    // R7 logic modes
    run(25'h15A5A5A, 18'h3C3C3, 48'hF0F0_0FF0_AAAA, 25'h0, 0, 0, 2'd3, 2'd0, 2'd2, 4'd4, "R7 AND");
    run(25'h15A5A5A, 18'h3C3C3, 48'hF0F0_0FF0_AAAA, 25'h0, 1, 0, 2'd3, 2'd3, 2'd2, 4'd6, "R7 XOR y ignored");
    run(25'h15A5A5A, 18'h3C3C3, 48'hF0F0_0FF0_AAAA, 25'h0, 0, 0, 2'd3, 2'd2, 2'd2, 4'd9, "R7 NOR");
    run(25'h15A5A5A, 18'h3C3C3, 48'hF0F0_0FF0_AAAA, 25'h0, 0, 0, 2'd3, 2'd0, 2'd2, 4'd10, "R7 NOT X");
    run(25'h15A5A5A, 18'h3C3C3, 48'hF0F0_0FF0_AAAA, 25'h0, 0, 0, 2'd3, 2'd0, 2'd2, 4'd13, "R7 X OR NOT Z");
    run(25'd77, 18'd5, 48'h1234_5678_9ABC, 25'h0, 0, 0, 2'd1, 2'd1, 2'd2, 4'd5, "R7 mult reads zero");

    // R5/R9 feedback with P frozen then released for one edge
    run(25'h0, 18'h0, 48'h1234_5678_9ABC, 25'h0, 0, 0, 2'd0, 2'd0, 2'd2, 4'd0, "R5 load C");
    held = p_model;
    @(negedge clk_i); ce_p_i = 1'b0;
    drive(25'h0, 18'h0, 48'h10, 25'h0, 0, 0, 2'd2, 2'd0, 2'd2, 4'd0);
    repeat (6) @(negedge clk_i);
    check("R9 hold piped", p_full, held);
    check("R9 hold bypassed", p_byp, held);
    ce_p_i = 1'b1;
    @(negedge clk_i); ce_p_i = 1'b0;
    check("R5 X=P piped", p_full, held + 48'h10);
    check("R5 X=P bypassed", p_byp, held + 48'h10);

    // R9 clear has priority over enable
    drive(25'h0, 18'h0, 48'd5, 25'h0, 0, 0, 2'd0, 2'd0, 2'd2, 4'd0);
    repeat (6) @(negedge clk_i);
    rst_p_i = 1'b1; ce_p_i = 1'b1;
    @(negedge clk_i); rst_p_i = 1'b0;
    check("R9 clear piped", p_full, '0);
    check("R9 clear bypassed", p_byp, '0);
    @(negedge clk_i);
    check("R9 resume piped", p_full, 48'd5);
    p_model = 48'd5;

    // R10 A-stage clear on piped copy; no effect where bypassed
    @(negedge clk_i); rst_a_i = 1'b1;
    drive(25'd1000, 18'd3, 48'd7, 25'h0, 0, 0, 2'd1, 2'd1, 2'd2, 4'd0);
    repeat (6) @(negedge clk_i);
    push(48'd7, 48'd3007, "R10 rst_a");
    @(negedge clk_i); rst_a_i = 1'b0;
    repeat (6) @(negedge clk_i);
    push(48'd3007, 48'd3007, "R10 release");

    // R11 asynchronous clear between edges
    #1 rst_ni = 1'b0;
    #0.5;
    check("R11 async piped", p_full, '0);
    check("R11 async bypassed", p_byp, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule